// File: doc/BRIEF.md
# Line-Splitting DMA Request Sequencer

This block takes one DMA transfer at a time, either a read or a write, described by a start byte address and a byte count. It cuts the transfer into chunks that never cross a cache-line boundary and sends them one by one on a downstream line port. Only the first chunk can start inside a line. Every later chunk starts on a line boundary. The block issues a chunk, then waits for that chunk's return before it issues the next. A write chunk's return is an acknowledge. A read chunk's return carries a full line of data.

Read bytes are gathered into a response buffer. When the last chunk returns, the block frees itself and presents one completion pulse. A requester that was turned away while the block was busy gets a one-cycle retry pulse when the block frees up. A drain handshake lets the surrounding system wait until nothing is outstanding.

Top module: `dmaseq_top`

## Requirements
- R1: Only one transfer is active at a time. While busy, `req_ready_o` is low and a request presented on `req_valid_i` is refused, not stored, and never produces a chunk.
- R2: A request refused while busy sets a pending flag. In the cycle after the final chunk's return, `retry_o` is high for exactly one cycle. `retry_o` stays low after transfers that refused nothing.
- R3: The first chunk has address `addr - (addr mod LINE_BYTES)`, offset `addr mod LINE_BYTES`, and length `min(len, LINE_BYTES - offset)`. `ln_store_o` is 1 for a write and 0 for a read.
- R4: Each later chunk starts at `addr + bytes_done`, has offset 0, and has length `min(len - bytes_done, LINE_BYTES)`.
- R5: A chunk appears in the cycle after acceptance or after the previous chunk's return. It is held stable while `ln_ready_i` is low. No new chunk appears between the `ln_ready_i` handshake and the matching `ln_resp_valid_i`.
- R6: Bit i of `ln_be_o` is 1 exactly when `offset <= i < offset + length`.
- R7: For a write chunk, line byte `offset + j` of `ln_wdata_o` (byte b sits at bits `8b+7:8b`) equals request byte `bytes_done + j`. Bytes outside the enable mask are zero.
- R8: For a read, response byte k (bits `8k+7:8k` of `rsp_data_o`) equals byte `offset + (k - bytes_done)` of the line returned for the chunk that covers k.
- R9: In the cycle after the final return, `req_ready_o` is high and `rsp_valid_o` pulses for one cycle, but only if `req_need_rsp_i` was 1 at acceptance.
- R10: A `drain_req_i` pulse while idle gives `drain_done_o` in the next cycle. While busy, it raises `draining_o` in the next cycle. `drain_done_o` then pulses, and `draining_o` falls, in the cycle after the final return.
- R11: A request with length 0 or more than `MAX_LEN` gives a one-cycle `req_err_o` in the next cycle, issues no chunk, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request present |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Byte count |
| req_need_rsp_i | input | 1 | Completion response wanted |
| req_wdata_i | input | MAX_LEN*8 | Write bytes, byte k at bits 8k+7:8k |
| req_err_o | output | 1 | Illegal length pulse |
| retry_o | output | 1 | Retry pulse for refused requester |
| ln_valid_o | output | 1 | Chunk valid |
| ln_ready_i | input | 1 | Chunk accepted downstream |
| ln_store_o | output | 1 | 1 = store chunk, 0 = load chunk |
| ln_addr_o | output | ADDR_W | Line base address |
| ln_off_o | output | OFF_W | Byte offset within line |
| ln_len_o | output | CL_W | Chunk byte count |
| ln_be_o | output | LINE_BYTES | Byte-enable mask |
| ln_wdata_o | output | LINE_BYTES*8 | Store data aligned in line |
| ln_resp_valid_i | input | 1 | Chunk return (ack or data) |
| ln_rdata_i | input | LINE_BYTES*8 | Returned line data |
| rsp_valid_o | output | 1 | Completion pulse |
| rsp_data_o | output | MAX_LEN*8 | Gathered read bytes |
| drain_req_i | input | 1 | Drain request pulse |
| draining_o | output | 1 | Drain waiting on active transfer |
| drain_done_o | output | 1 | Drain complete pulse |

## Verification
A chunk is due in the cycle after the edge that accepted the request or took the previous return. Every completion output is due in the cycle after the edge that takes the final return: `rsp_valid_o`, `retry_o`, `drain_done_o`, and the rise of `req_ready_o`. `req_err_o` is due the cycle after the rejected request. `draining_o` is due the cycle after the drain pulse. The bench drives on falling edges and samples at the following falling edge, so each check lands exactly in the cycle its result is due. It also holds `ln_ready_i` low for one cycle and delays every return by two cycles, which exposes early issue and unstable chunks. A sweep covers every start offset in a line with every legal length, for both reads and writes.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_e;
endpackage

// File: rtl/dmaseq_chunk.sv
module dmaseq_chunk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 9,
  parameter int OFF_W      = $clog2(LINE_BYTES),
  parameter int CL_W       = $clog2(LINE_BYTES + 1)
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic [LEN_W-1:0]      done_i,
  output logic [ADDR_W-1:0]     base_o,
  output logic [OFF_W-1:0]      off_o,
  output logic [CL_W-1:0]       clen_o,
  output logic [LINE_BYTES-1:0] be_o
);
  logic [ADDR_W-1:0] cur;
  logic [31:0]       rem, room, span;

  assign cur    = addr_i + ADDR_W'(done_i);
  assign off_o  = cur[OFF_W-1:0];
  assign base_o = {cur[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign rem    = 32'(len_i) - 32'(done_i);
  assign room   = 32'(LINE_BYTES) - 32'(off_o);
  assign span   = (rem < room) ? rem : room;
  assign clen_o = CL_W'(span);

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_be
    assign be_o[i] = (32'(i) >= 32'(off_o)) && (32'(i) < 32'(off_o) + 32'(clen_o));
  end
endmodule

// File: rtl/dmaseq_wpack.sv
module dmaseq_wpack #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  parameter int LEN_W      = 9,
  parameter int OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    load_i,
  input  logic [MAX_LEN*8-1:0]    data_i,
  input  logic [LEN_W-1:0]        done_i,
  input  logic [OFF_W-1:0]        off_i,
  input  logic [LINE_BYTES-1:0]   be_i,
  output logic [LINE_BYTES*8-1:0] line_o
);
  logic [MAX_LEN*8-1:0] data_q;

  always_ff @(posedge clk_i) begin
    if (load_i) data_q <= data_i;
  end

  // line byte i takes request byte done + (i - off)
  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
    logic [31:0] idx;
    assign idx = 32'(done_i) + 32'(i) - 32'(off_i);
    assign line_o[i*8 +: 8] = (be_i[i] && idx < 32'(MAX_LEN)) ? data_q[idx*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/dmaseq_rgather.sv
module dmaseq_rgather #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  parameter int LEN_W      = 9,
  parameter int OFF_W      = $clog2(LINE_BYTES),
  parameter int CL_W       = $clog2(LINE_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LEN_W-1:0]        done_i,
  input  logic [OFF_W-1:0]        off_i,
  input  logic [CL_W-1:0]         clen_i,
  input  logic [LINE_BYTES*8-1:0] line_i,
  output logic [MAX_LEN*8-1:0]    data_o
);
  // buffer byte k takes line byte off + (k - done) when inside the chunk window
  for (genvar k = 0; k < MAX_LEN; k++) begin : g_byte
    logic [31:0]      rel;
    logic             hit;
    logic [OFF_W-1:0] src;
    logic [7:0]       byte_q;
    assign rel = 32'(k) - 32'(done_i);
    assign hit = we_i && (32'(k) >= 32'(done_i)) && (rel < 32'(clen_i));
    assign src = OFF_W'(rel + 32'(off_i));
    always_ff @(posedge clk_i) begin
      if (hit) byte_q <= line_i[{src, 3'b000} +: 8];
    end
    assign data_o[k*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CL_W      = $clog2(LINE_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [LEN_W-1:0]        req_len_i,
  input  logic                    req_need_rsp_i,
  input  logic [MAX_LEN*8-1:0]    req_wdata_i,
  output logic                    req_err_o,
  output logic                    retry_o,
  output logic                    ln_valid_o,
  input  logic                    ln_ready_i,
  output logic                    ln_store_o,
  output logic [ADDR_W-1:0]       ln_addr_o,
  output logic [OFF_W-1:0]        ln_off_o,
  output logic [CL_W-1:0]         ln_len_o,
  output logic [LINE_BYTES-1:0]   ln_be_o,
  output logic [LINE_BYTES*8-1:0] ln_wdata_o,
  input  logic                    ln_resp_valid_i,
  input  logic [LINE_BYTES*8-1:0] ln_rdata_i,
  output logic                    rsp_valid_o,
  output logic [MAX_LEN*8-1:0]    rsp_data_o,
  input  logic                    drain_req_i,
  output logic                    draining_o,
  output logic                    drain_done_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, done_q, issued_q;
  logic              write_q, need_q, pend_q;
  logic              busy, len_ok, accept, refuse, take, last;

  assign busy   = (state_q != ST_IDLE);
  assign len_ok = (req_len_i != '0) && (32'(req_len_i) <= 32'(MAX_LEN));
  assign accept = req_valid_i && !busy && len_ok;
  assign refuse = req_valid_i && busy;
  assign take   = (state_q == ST_WAIT) && ln_resp_valid_i;
  assign last   = take && (issued_q == len_q);

  assign req_ready_o = !busy;
  assign ln_valid_o  = (state_q == ST_ISSUE);
  assign ln_store_o  = write_q;

  dmaseq_chunk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)) u_chunk (
    .addr_i(addr_q), .len_i(len_q), .done_i(done_q),
    .base_o(ln_addr_o), .off_o(ln_off_o), .clen_o(ln_len_o), .be_o(ln_be_o)
  );

  dmaseq_wpack #(.LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_wpack (
    .clk_i(clk_i), .load_i(accept), .data_i(req_wdata_i), .done_i(done_q),
    .off_i(ln_off_o), .be_i(ln_be_o), .line_o(ln_wdata_o)
  );

  dmaseq_rgather #(.LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_rgather (
    .clk_i(clk_i), .we_i(take && !write_q), .done_i(done_q), .off_i(ln_off_o),
    .clen_i(ln_len_o), .line_i(ln_rdata_i), .data_o(rsp_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      len_q    <= '0;
      done_q   <= '0;
      issued_q <= '0;
      write_q  <= 1'b0;
      need_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          len_q   <= req_len_i;
          write_q <= req_write_i;
          need_q  <= req_need_rsp_i;
          done_q  <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (ln_ready_i) begin
          issued_q <= done_q + LEN_W'(ln_len_o);
          state_q  <= ST_WAIT;
        end
        ST_WAIT: if (take) begin
          done_q  <= issued_q;
          state_q <= last ? ST_IDLE : ST_ISSUE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // completion side: busy drops on the same edge these pulses are registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      retry_o      <= 1'b0;
      rsp_valid_o  <= 1'b0;
      req_err_o    <= 1'b0;
      draining_o   <= 1'b0;
      drain_done_o <= 1'b0;
    end else begin
      pend_q       <= last ? 1'b0 : (pend_q || refuse);
      retry_o      <= last && (pend_q || refuse);
      rsp_valid_o  <= last && need_q;
      req_err_o    <= req_valid_i && !busy && !len_ok;
      draining_o   <= last ? 1'b0 : (draining_o || (drain_req_i && busy));
      drain_done_o <= (drain_req_i && (!busy || last)) || (draining_o && last);
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_valid_o |-> !req_ready_o); // R1
  AST_RETRY_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> req_ready_o); // R2
  AST_CHUNK_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_valid_o |-> (ln_len_o != '0) && (32'(ln_off_o) + 32'(ln_len_o) <= 32'(LINE_BYTES))); // R3
  AST_LATER_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ln_valid_o && done_q != '0) |-> (ln_off_o == '0)); // R4
  AST_CHUNK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ln_valid_o && !ln_ready_i) |=> ln_valid_o && $stable(ln_addr_o) && $stable(ln_len_o)); // R5
  AST_BE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_valid_o |-> ($countones(ln_be_o) == 32'(ln_len_o))); // R6
  AST_RSP_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o); // R9
  AST_DRAIN_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_done_o |-> (req_ready_o && !draining_o)); // R10
  AST_ERR_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> !ln_valid_o); // R11
endmodule

// File: tb/sim_dmaseq_top.sv
`timescale 1ns/1ps
module sim_dmaseq_top;
  localparam int AW = 16;
  localparam int LB = 8;
  localparam int ML = 24;
  localparam int OW = $clog2(LB);
  localparam int LW = $clog2(ML + 1);
  localparam int CW = $clog2(LB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid_i = 0, req_write_i = 0, req_need_rsp_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic [ML*8-1:0] req_wdata_i = '0;
  logic ln_ready_i = 0, ln_resp_valid_i = 0, drain_req_i = 0;
  logic [LB*8-1:0] ln_rdata_i = '0;
  logic req_ready_o, req_err_o, retry_o, ln_valid_o, ln_store_o;
  logic [AW-1:0] ln_addr_o;
  logic [OW-1:0] ln_off_o;
  logic [CW-1:0] ln_len_o;
  logic [LB-1:0] ln_be_o;
  logic [LB*8-1:0] ln_wdata_o;
  logic rsp_valid_o, draining_o, drain_done_o;
  logic [ML*8-1:0] rsp_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dmaseq_top #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_LEN(ML)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_need_rsp_i(req_need_rsp_i),
    .req_wdata_i(req_wdata_i), .req_err_o(req_err_o), .retry_o(retry_o),
    .ln_valid_o(ln_valid_o), .ln_ready_i(ln_ready_i), .ln_store_o(ln_store_o),
    .ln_addr_o(ln_addr_o), .ln_off_o(ln_off_o), .ln_len_o(ln_len_o), .ln_be_o(ln_be_o),
    .ln_wdata_o(ln_wdata_o), .ln_resp_valid_i(ln_resp_valid_i), .ln_rdata_i(ln_rdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .drain_req_i(drain_req_i),
    .draining_o(draining_o), .drain_done_o(drain_done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mpat(input int a);
    return 8'((a * 5 + 1) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] wpat(input int seed, input int k);
    return 8'(k * 29 + seed);
  endfunction

  task automatic xfer(input bit w, input int a, input int l, input bit nr,
                      input bit poke, input bit drn);
    int done, off, clen, base, bad;
    bit first;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1 ready when idle", int'(req_ready_o), 1);
    req_valid_i = 1; req_write_i = w; req_addr_i = AW'(a); req_len_i = LW'(l);
    req_need_rsp_i = nr;
    for (int k = 0; k < ML; k++) req_wdata_i[k*8 +: 8] = wpat(a, k);
    @(negedge clk);
    req_valid_i = 0;
    chk(req_ready_o == 1'b0, "R1 busy after accept", int'(req_ready_o), 0);
    done = 0;
    first = 1;
    while (done < l) begin
      off  = (a + done) % LB;
      clen = l - done;
      if (LB - off < clen) clen = LB - off;
      base = (a + done) - off;
      chk(ln_valid_o == 1'b1, "R5 chunk due", int'(ln_valid_o), 1);
      if (first) begin
        chk(int'(ln_addr_o) == base, "R3 first addr", int'(ln_addr_o), base);
        chk(int'(ln_off_o) == off, "R3 first offset", int'(ln_off_o), off);
        chk(int'(ln_len_o) == clen, "R3 first length", int'(ln_len_o), clen);
        chk(ln_store_o == w, "R3 store bit", int'(ln_store_o), int'(w));
      end else begin
        chk(int'(ln_addr_o) == base, "R4 later addr", int'(ln_addr_o), base);
        chk(ln_off_o == '0, "R4 later offset", int'(ln_off_o), 0);
        chk(int'(ln_len_o) == clen, "R4 later length", int'(ln_len_o), clen);
      end
      bad = 0;
      for (int i = 0; i < LB; i++)
        if (ln_be_o[i] != ((i >= off) && (i < off + clen))) bad++;
      chk(bad == 0, "R6 byte enables", int'(ln_be_o), bad);
      if (w) begin
        bad = 0;
        for (int i = 0; i < LB; i++) begin
          if ((i >= off) && (i < off + clen)) begin
            if (ln_wdata_o[i*8 +: 8] != wpat(a, done + i - off)) bad++;
          end else if (ln_wdata_o[i*8 +: 8] != 8'h00) bad++;
        end
        chk(bad == 0, "R7 write lanes", bad, 0);
      end
      if (first && poke) req_valid_i = 1;
      if (first && drn) drain_req_i = 1;
      @(negedge clk);
      if (first && poke) chk(req_ready_o == 1'b0, "R1 refused while busy", int'(req_ready_o), 0);
      if (first && drn) chk(draining_o && !drain_done_o, "R10 draining raised", int'(draining_o), 1);
      req_valid_i = 0;
      drain_req_i = 0;
      chk(ln_valid_o && int'(ln_addr_o) == base && int'(ln_len_o) == clen,
          "R5 held while not ready", int'(ln_len_o), clen);
      ln_ready_i = 1;
      @(negedge clk);
      ln_ready_i = 0;
      chk(ln_valid_o == 1'b0, "R5 no issue before return", int'(ln_valid_o), 0);
      @(negedge clk);
      chk(ln_valid_o == 1'b0, "R5 still waiting", int'(ln_valid_o), 0);
      ln_resp_valid_i = 1;
      for (int i = 0; i < LB; i++) ln_rdata_i[i*8 +: 8] = w ? 8'hEE : mpat(base + i);
      @(negedge clk);
      ln_resp_valid_i = 0;
      done += clen;
      first = 0;
    end
    chk(rsp_valid_o == nr, "R9 response pulse", int'(rsp_valid_o), int'(nr));
    chk(req_ready_o == 1'b1, "R9 free at completion", int'(req_ready_o), 1);
    chk(retry_o == poke, "R2 retry pulse", int'(retry_o), int'(poke));
    if (drn) chk(drain_done_o && !draining_o, "R10 drain done at completion", int'(drain_done_o), 1);
    if (!w && nr) begin
      bad = 0;
      for (int k = 0; k < l; k++)
        if (rsp_data_o[k*8 +: 8] != mpat(a + k)) bad++;
      chk(bad == 0, "R8 gathered read bytes", bad, 0);
    end
    @(negedge clk);
    chk(!rsp_valid_o && !retry_o, "R2 R9 single-cycle pulses", int'(rsp_valid_o), 0);
    chk(!ln_valid_o, "R1 refused request not queued", int'(ln_valid_o), 0);
  endtask

  task automatic bad_len(input int l);
    @(negedge clk);
    req_valid_i = 1; req_len_i = LW'(l); req_addr_i = AW'(3);
    @(negedge clk);
    req_valid_i = 0;
    chk(req_err_o == 1'b1, "R11 error pulse", int'(req_err_o), 1);
    chk(!ln_valid_o && req_ready_o, "R11 nothing started", int'(ln_valid_o), 0);
    @(negedge clk);
    chk(!req_err_o && !ln_valid_o, "R11 pulse ends, idle", int'(req_err_o), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready_o && !ln_valid_o && !rsp_valid_o && !retry_o && !req_err_o
        && !draining_o && !drain_done_o, "R1 reset state", int'(ln_valid_o), 0);
    rst_n = 1;
    @(negedge clk);
    drain_req_i = 1;
    @(negedge clk);
    drain_req_i = 0;
    chk(drain_done_o && !draining_o, "R10 idle drain immediate", int'(drain_done_o), 1);
    @(negedge clk);
    chk(!drain_done_o, "R10 idle drain single pulse", int'(drain_done_o), 0);
    bad_len(0);
    bad_len(ML + 1);
    for (int w = 0; w < 2; w++)
      for (int o = 0; o < LB; o++)
        for (int l = 1; l <= ML; l++)
          xfer(w[0], 16'h0140 + o + 8 * w, l, (l % 4) != 2, (l % 5) == 0, (l % 7) == 3);
    finish_run();
  end
endmodule